// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This unit decides, once per instruction boundary, whether one of many pending interrupt requests may be taken by the processor core. Each of the maskable sources carries a programmable priority level. A lower number is a more urgent level. A single non-maskable request carries a fixed level set by a parameter. The unit picks one winner among all active requests. It then tests that winner against the current level mask and the global interrupt enable.

The decision takes effect only on a clock edge where the core signals a break between instructions. At that edge the unit emits a one-cycle accept pulse with the winning interrupt number registered beside it. Fetching the handler vector and saving state are left to the core.

The winner can be picked by a balanced comparison tree or by a linear scan. A parameter chooses between them, and both give identical results.

Top module: `irq_accept_unit`

## Requirements
- R1: Among all active requests (maskable sources whose `irq_req` bit is 1, plus `nmi_req`), the winner is the one with the numerically smallest level.
- R2: Among active requests of equal level, the winner is the one with the smallest interrupt number. Maskable source i has number i, and the non-maskable request has number NUM_SRC (32 by default). A maskable source therefore beats the non-maskable request when their levels are equal.
- R3: The level of maskable source i is `irq_level[i*LVL_W +: LVL_W]`. The non-maskable request always uses the constant level NMI_LEVEL (4 by default).
- R4: When the winner's level is greater than or equal to `level_mask`, nothing is accepted. No other request is tried in its place.
- R5: When the winner is a maskable source and `int_enable` is 0, nothing is accepted.
- R6: When the winner is the non-maskable request and its level is below `level_mask`, it is accepted whatever the value of `int_enable`.
- R7: `accept` is 1 for exactly the one cycle after a rising clock edge at which `insn_boundary` was 1 and the conditions of R1 to R6 held. `accept_num` is loaded at that same edge and holds its value at every other edge.
- R8: While `rst_n` is 0, `accept` is 0 and `accept_num` is 0.
- R9: A source whose level is 31 (all ones) is never accepted, because no mask value can exceed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Maskable request lines, bit i for source i |
| nmi_req | input | 1 | Non-maskable request |
| irq_level | input | NUM_SRC*LVL_W | Packed per-source levels, source i at bits i*LVL_W and up |
| level_mask | input | LVL_W | Current interrupt level mask |
| int_enable | input | 1 | Global enable for maskable requests |
| insn_boundary | input | 1 | High in the cycle where an instruction break occurs |
| accept | output | 1 | One-cycle acceptance pulse |
| accept_num | output | NUM_W | Number of the accepted interrupt, held between pulses |

## Verification
Every result in this unit is due exactly one clock edge after the inputs that cause it. The bench therefore drives a new input set on a falling edge and computes the expected pulse and number from that set. It then waits for the following rising edge and compares on the next falling edge, before it changes any input. The expected number is held in the bench and updated only when a pulse is expected, so the hold behaviour of R7 is checked on every cycle without a pulse. Directed cases cover ties, the mask boundary, the enable bypass, level 31 and strobe-off cycles. These are mixed with seeded random traffic.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   // Candidates: every maskable source plus the non-maskable request.
   function automatic int cand_count(input int num_src);
      return num_src + 1;
   endfunction

   // Width able to carry every candidate number, NMI included.
   function automatic int num_width(input int num_src);
      return (num_src + 1 <= 2) ? 1 : $clog2(num_src + 1);
   endfunction

   // Selection structure variants.
   localparam int PICK_SCAN = 0;
   localparam int PICK_TREE = 1;

endpackage

// File: rtl/irq_pick_scan.sv
module irq_pick_scan #(
   parameter int N_CAND = 33,
   parameter int LVL_W  = 5,
   parameter int NUM_W  = 6
) (
   input  logic [N_CAND-1:0]       cand_valid,
   input  logic [N_CAND*LVL_W-1:0] cand_lvl,
   output logic                    win_valid,
   output logic [LVL_W-1:0]        win_lvl,
   output logic [NUM_W-1:0]        win_num
);

   // Ascending walk; only a strictly lower level replaces the holder,
   // so equal levels keep the smaller number.
   always_comb begin
      win_valid = 1'b0;
      win_lvl   = '1;
      win_num   = '0;
      for (int i = 0; i < N_CAND; i++) begin
         if (cand_valid[i] &&
             (!win_valid || (cand_lvl[i*LVL_W +: LVL_W] < win_lvl))) begin
            win_valid = 1'b1;
            win_lvl   = cand_lvl[i*LVL_W +: LVL_W];
            win_num   = NUM_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree #(
   parameter int N_CAND = 33,
   parameter int LVL_W  = 5,
   parameter int NUM_W  = 6
) (
   input  logic [N_CAND-1:0]       cand_valid,
   input  logic [N_CAND*LVL_W-1:0] cand_lvl,
   output logic                    win_valid,
   output logic [LVL_W-1:0]        win_lvl,
   output logic [NUM_W-1:0]        win_num
);

   localparam int DEPTH = (N_CAND <= 1) ? 1 : $clog2(N_CAND);
   localparam int LEAVES = 1 << DEPTH;
   localparam int NODES = 2 * LEAVES - 1;
   localparam int FIRST_LEAF = LEAVES - 1;

   // Heap layout: node k has children 2k+1 (lower numbers) and 2k+2.
   logic [NODES-1:0] nd_v;
   logic [LVL_W-1:0] nd_l [NODES];
   logic [NUM_W-1:0] nd_n [NODES];

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < N_CAND) begin : g_real
         assign nd_v[FIRST_LEAF+i] = cand_valid[i];
         assign nd_l[FIRST_LEAF+i] = cand_lvl[i*LVL_W +: LVL_W];
         assign nd_n[FIRST_LEAF+i] = NUM_W'(i);
      end else begin : g_pad
         assign nd_v[FIRST_LEAF+i] = 1'b0;
         assign nd_l[FIRST_LEAF+i] = '1;
         assign nd_n[FIRST_LEAF+i] = '0;
      end
   end

   for (genvar k = 0; k < FIRST_LEAF; k++) begin : g_node
      logic take_lo;
      // The lower-numbered side wins ties.
      assign take_lo = nd_v[2*k+1] &&
                       (!nd_v[2*k+2] || (nd_l[2*k+1] <= nd_l[2*k+2]));
      assign nd_v[k] = nd_v[2*k+1] | nd_v[2*k+2];
      assign nd_l[k] = take_lo ? nd_l[2*k+1] : nd_l[2*k+2];
      assign nd_n[k] = take_lo ? nd_n[2*k+1] : nd_n[2*k+2];
   end

   assign win_valid = nd_v[0];
   assign win_lvl   = nd_l[0];
   assign win_num   = nd_n[0];

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int LVL_W = 5
) (
   input  logic             win_valid,
   input  logic [LVL_W-1:0] win_lvl,
   input  logic             win_is_nmi,
   input  logic [LVL_W-1:0] level_mask,
   input  logic             int_enable,
   output logic             grant
);

   logic below_mask;
   logic enable_ok;

   assign below_mask = win_lvl < level_mask;
   assign enable_ok  = win_is_nmi | int_enable;
   assign grant      = win_valid & below_mask & enable_ok;

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int NUM_SRC    = 32,
   parameter int LVL_W      = 5,
   parameter int NMI_LEVEL  = 4,
   parameter int PICK_STYLE = PICK_TREE,
   parameter int NUM_W      = num_width(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       irq_req,
   input  logic                     nmi_req,
   input  logic [NUM_SRC*LVL_W-1:0] irq_level,
   input  logic [LVL_W-1:0]         level_mask,
   input  logic                     int_enable,
   input  logic                     insn_boundary,
   output logic                     accept,
   output logic [NUM_W-1:0]         accept_num
);

   localparam int N_CAND = cand_count(NUM_SRC);
   localparam logic [NUM_W-1:0] NMI_NUM = NUM_W'(NUM_SRC);
   localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NMI_LEVEL);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end
   if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
      $error("LVL_W must lie in 1..16");
   end
   if (NMI_LEVEL < 0 || NMI_LEVEL >= (1 << LVL_W)) begin : g_bad_nmi
      $error("NMI_LEVEL does not fit in LVL_W bits");
   end
   if ((1 << NUM_W) < N_CAND) begin : g_bad_numw
      $error("NUM_W too narrow for NMI number");
   end
   if (PICK_STYLE != PICK_SCAN && PICK_STYLE != PICK_TREE) begin : g_bad_style
      $error("PICK_STYLE must select scan or tree");
   end

   logic [N_CAND-1:0]       cand_valid;
   logic [N_CAND*LVL_W-1:0] cand_lvl;
   logic                    win_valid;
   logic [LVL_W-1:0]        win_lvl;
   logic [NUM_W-1:0]        win_num;
   logic                    win_is_nmi;
   logic                    grant;

   assign cand_valid = {nmi_req, irq_req};
   assign cand_lvl   = {NMI_LVL, irq_level};

   if (PICK_STYLE == PICK_TREE) begin : g_tree
      irq_pick_tree #(
         .N_CAND (N_CAND),
         .LVL_W  (LVL_W),
         .NUM_W  (NUM_W)
      ) u_pick (
         .cand_valid (cand_valid),
         .cand_lvl   (cand_lvl),
         .win_valid  (win_valid),
         .win_lvl    (win_lvl),
         .win_num    (win_num)
      );
   end else begin : g_scan
      irq_pick_scan #(
         .N_CAND (N_CAND),
         .LVL_W  (LVL_W),
         .NUM_W  (NUM_W)
      ) u_pick (
         .cand_valid (cand_valid),
         .cand_lvl   (cand_lvl),
         .win_valid  (win_valid),
         .win_lvl    (win_lvl),
         .win_num    (win_num)
      );
   end

   assign win_is_nmi = (win_num == NMI_NUM);

   irq_gate #(
      .LVL_W (LVL_W)
   ) u_gate (
      .win_valid  (win_valid),
      .win_lvl    (win_lvl),
      .win_is_nmi (win_is_nmi),
      .level_mask (level_mask),
      .int_enable (int_enable),
      .grant      (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept     <= 1'b0;
         accept_num <= '0;
      end else begin
         accept <= grant & insn_boundary;
         if (grant && insn_boundary) begin
            accept_num <= win_num;
         end
      end
   end

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
   parameter int NUM_SRC   = 32,
   parameter int LVL_W     = 5,
   parameter int NMI_LEVEL = 4,
   parameter int NUM_W     = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_SRC-1:0]       irq_req,
   input logic                     nmi_req,
   input logic [NUM_SRC*LVL_W-1:0] irq_level,
   input logic [LVL_W-1:0]         level_mask,
   input logic                     int_enable,
   input logic                     insn_boundary,
   input logic                     accept,
   input logic [NUM_W-1:0]         accept_num
);

   logic [NUM_SRC-1:0]       p_req;
   logic                     p_nmi;
   logic [NUM_SRC*LVL_W-1:0] p_lvl;
   logic [LVL_W-1:0]         p_mask;
   logic                     p_ie;
   logic                     p_bnd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_req  <= '0;
         p_nmi  <= 1'b0;
         p_lvl  <= '0;
         p_mask <= '0;
         p_ie   <= 1'b0;
         p_bnd  <= 1'b0;
      end else begin
         p_req  <= irq_req;
         p_nmi  <= nmi_req;
         p_lvl  <= irq_level;
         p_mask <= level_mask;
         p_ie   <= int_enable;
         p_bnd  <= insn_boundary;
      end
   end

   logic             acc_nmi;
   logic [LVL_W-1:0] acc_lvl;
   logic             acc_was_req;
   logic [LVL_W:0]   min_lvl;

   assign acc_nmi = (int'(accept_num) == NUM_SRC);

   always_comb begin
      acc_lvl     = LVL_W'(NMI_LEVEL);
      acc_was_req = p_nmi;
      if (!acc_nmi && int'(accept_num) < NUM_SRC) begin
         acc_lvl     = p_lvl[int'(accept_num)*LVL_W +: LVL_W];
         acc_was_req = p_req[int'(accept_num)];
      end
      min_lvl = p_nmi ? (LVL_W+1)'(NMI_LEVEL) : {1'b1, {LVL_W{1'b0}}};
      for (int i = 0; i < NUM_SRC; i++) begin
         if (p_req[i] && ({1'b0, p_lvl[i*LVL_W +: LVL_W]} < min_lvl)) begin
            min_lvl = {1'b0, p_lvl[i*LVL_W +: LVL_W]};
         end
      end
   end

   a_r7_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> p_bnd);

   a_r7_num_held: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |-> $stable(accept_num));

   a_r1_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> acc_was_req);

   a_r1_lowest_level: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ({1'b0, acc_lvl} == min_lvl));

   a_r4_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (acc_lvl < p_mask));

   a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !acc_nmi) |-> p_ie);

   a_r9_never_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (acc_lvl != '1));

endmodule

bind irq_accept_unit irq_accept_chk #(
   .NUM_SRC   (NUM_SRC),
   .LVL_W     (LVL_W),
   .NMI_LEVEL (NMI_LEVEL),
   .NUM_W     (NUM_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_req       (irq_req),
   .nmi_req       (nmi_req),
   .irq_level     (irq_level),
   .level_mask    (level_mask),
   .int_enable    (int_enable),
   .insn_boundary (insn_boundary),
   .accept        (accept),
   .accept_num    (accept_num)
);

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NS  = 32;
   localparam int LW  = 5;
   localparam int NW  = 6;
   localparam int NMI_LV = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NS-1:0]      irq_req = '0;
   logic               nmi_req = 1'b0;
   logic [NS*LW-1:0]   irq_level = '1;
   logic [LW-1:0]      level_mask = '0;
   logic               int_enable = 1'b0;
   logic               insn_boundary = 1'b0;
   logic               accept;
   logic [NW-1:0]      accept_num;

   int n_checks = 0;
   int n_fail = 0;
   logic [NW-1:0] exp_num = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_accept_unit #(
      .NUM_SRC   (NS),
      .LVL_W     (LW),
      .NMI_LEVEL (NMI_LV)
   ) i_irq_accept_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_req       (irq_req),
      .nmi_req       (nmi_req),
      .irq_level     (irq_level),
      .level_mask    (level_mask),
      .int_enable    (int_enable),
      .insn_boundary (insn_boundary),
      .accept        (accept),
      .accept_num    (accept_num)
   );

   function automatic void model(output logic acc, output logic [NW-1:0] num);
      int best_lvl = 99;
      int best_num = -1;
      for (int i = 0; i <= NS; i++) begin
         int lv;
         logic act;
         if (i < NS) begin
            act = irq_req[i];
            lv  = int'(irq_level[i*LW +: LW]);
         end else begin
            act = nmi_req;
            lv  = NMI_LV;
         end
         if (act && lv < best_lvl) begin
            best_lvl = lv;
            best_num = i;
         end
      end
      acc = insn_boundary && best_num >= 0 && best_lvl < int'(level_mask) &&
            (best_num == NS || int_enable);
      num = (best_num >= 0) ? NW'(best_num) : '0;
   endfunction

   task automatic check(input string req, input logic [NW:0] got, input logic [NW:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // Inputs are already driven (at a falling edge); one rising edge, then compare.
   task automatic step(input string req);
      logic e_acc;
      logic [NW-1:0] e_num;
      model(e_acc, e_num);
      if (e_acc) exp_num = e_num;
      @(posedge clk);
      @(negedge clk);
      check(req, {accept, accept_num}, {e_acc, exp_num});
   endtask

   task automatic quiet();
      irq_req = '0;
      nmi_req = 1'b0;
      irq_level = '1;
   endtask

   task automatic set_lvl(input int src, input int lv);
      irq_level[src*LW +: LW] = LW'(lv);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1a2b));
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", {accept, accept_num}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: tie at level 2 between sources 7 and 3 -> 3
      quiet(); set_lvl(3, 2); set_lvl(7, 2); irq_req[3] = 1; irq_req[7] = 1;
      level_mask = 10; int_enable = 1; insn_boundary = 1;
      step("R2");
      check("R2 num", {1'b0, accept_num}, {1'b0, NW'(3)});

      // R7: strobe low -> nothing, number held at 3
      insn_boundary = 0;
      step("R7");

      // R1/R3: source 20 at level 1 beats source 3 at level 2
      insn_boundary = 1; set_lvl(20, 1); irq_req[20] = 1;
      step("R1");

      // R6: NMI (level 4) with enable off is taken
      quiet(); nmi_req = 1; int_enable = 0; level_mask = 5;
      step("R6");
      check("R6 num", {1'b0, accept_num}, {1'b0, NW'(NS)});

      // R5: maskable level 1 wins over NMI, enable off -> nothing
      set_lvl(9, 1); irq_req[9] = 1;
      step("R5");

      // R2: NMI and source 0 tie at level 4 -> source 0
      quiet(); nmi_req = 1; set_lvl(0, NMI_LV); irq_req[0] = 1; int_enable = 1;
      level_mask = 10;
      step("R2 nmi tie");

      // R4: level equal to mask -> nothing, no fallback
      quiet(); set_lvl(5, 6); irq_req[5] = 1; level_mask = 6;
      step("R4 equal");
      level_mask = 7;
      step("R4 below");

      // R9: level 31 with maximum mask
      quiet(); set_lvl(12, 31); irq_req[12] = 1; level_mask = '1;
      step("R9");

      // R3: NMI level bound by mask 4 -> rejected
      quiet(); nmi_req = 1; level_mask = NMI_LV;
      step("R3 nmi mask");

      // R7: back-to-back pulses on consecutive boundaries
      quiet(); set_lvl(30, 0); irq_req[30] = 1; level_mask = 1;
      step("R7 first");
      step("R7 second");

      // R1: seeded random traffic
      for (int n = 0; n < 4000; n++) begin
         irq_req = $urandom() & $urandom();
         nmi_req = ($urandom_range(7) == 0);
         for (int s = 0; s < NS; s++) begin
            set_lvl(s, ($urandom_range(5) == 0) ? 31 : int'($urandom_range(31)));
         end
         level_mask = LW'($urandom_range(31));
         int_enable = ($urandom_range(3) != 0);
         insn_boundary = ($urandom_range(9) < 7);
         step("R1 random");
      end

      // R8: asynchronous reset clears outputs
      rst_n = 1'b0;
      #1;
      check("R8 again", {accept, accept_num}, '0);
      exp_num = '0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule